// File: doc/BRIEF.md
# Dual-Mode Configuration Word Loader

This block collects a 40-bit configuration word for a frequency synthesis core and hands it over as a unit. A host writes the staging register over an 8-bit bus in one of two ways. In byte mode, five successive write-clock pulses fill it one byte at a time. In bit mode, forty pulses shift it in from a single data line. A separate update strobe copies the staged word into the active register. The active register drives the 32-bit tuning value, the 5-bit phase offset, the clock-multiplier enable and the power-down control.

The write clock and the update strobe are asynchronous to the system clock. Each one passes through a synchronizer and a rising-edge detector before it acts. The data bus is sampled when the detected write event fires, so the host holds it stable for the whole pulse. Reset restores the control defaults but keeps the staging register contents. A word whose reserved test bit is set is refused at transfer time.

Top module: `cfg_loader`

## Requirements
- R1: While rst_ni is low and after it is released, tune_o, phase_o, mult_en_o, pwr_dn_o, serial_mode_o and test_err_o are all 0.
- R2: In byte mode, write events store data_i into bytes B0 to B4 in that order. The staged word is B0..B4, most significant first. B0 bits [7:3] are the phase, bit 2 is power-down, bit 1 is the test bit and bit 0 is the multiplier enable. B1 holds tuning bits [31:24] and B4 holds tuning bits [7:0].
- R3: After five bytes, further write events leave the staged word unchanged until an update or a reset.
- R4: An update event returns the byte pointer to B0. Writing only B0 and then updating changes only the B0 fields, and the tuning value comes from the retained bytes.
- R5: A byte-mode write to B0 whose bits [2:0] are 3'b011 switches the block to bit mode. serial_mode_o then stays 1 until reset, and reset selects byte mode.
- R6: In bit mode, each write event shifts data_i[7] into the staged word. After forty events, the first bit sent is tuning bit 0 and bit 31 is tuning bit 31. Bits 32, 33 and 34 are the multiplier enable, the test bit and power-down. Bits 35 to 39 are phase bits 0 to 4.
- R7: In bit mode, write events beyond forty keep shifting, so the oldest bit is lost and every other bit moves down by one position.
- R8: Reset does not clear the staged word, so an update after reset transfers the bytes written before reset.
- R9: An update whose staged test bit is 1 leaves the active outputs unchanged and sets test_err_o. The next accepted update clears test_err_o.
- R10: The staging register accepts writes while pwr_dn_o is 1.
- R11: The active outputs change only on an update event. With SYNC_STAGES=2, they change on the third system-clock edge after upd_i rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_clk_i | input | 1 | Asynchronous write clock; its rising edge writes a byte or a bit |
| upd_i | input | 1 | Asynchronous update strobe; its rising edge transfers the staged word |
| data_i | input | 8 | Write data; bit 7 is the serial line in bit mode |
| tune_o | output | 32 | Active tuning value |
| phase_o | output | 5 | Active phase offset |
| mult_en_o | output | 1 | Active clock-multiplier enable |
| pwr_dn_o | output | 1 | Active power-down control |
| serial_mode_o | output | 1 | 1 while bit mode is selected |
| test_err_o | output | 1 | Last transfer was refused because the test bit was set |

## Verification
The bench builds the block with its default SYNC_STAGES=2. This fixes a three-edge latency from a strobe rising to the active outputs, so the bench can sample one edge before and one edge after the transfer and confirm the exact cycle. With this depth, a pulse of four system cycles high and four low is enough for every write to be seen exactly once. That lets the bench run the full forty-one-pulse shift sequence and the overrun of the byte pointer with simple directed pulses.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = 5;
  localparam int WORD_W    = BYTE_W * NUM_BYTES;
  localparam int TUNE_W    = 32;
  localparam int PHASE_W   = 5;
  localparam int PTR_W     = $clog2(NUM_BYTES + 1);
  localparam int TEST_POS  = TUNE_W + 1;
  localparam logic [2:0] MODE_KEY = 3'b011;

  // layout matches serial bit order: bit 0 enters first
  typedef struct packed {
    logic [PHASE_W-1:0] phase;
    logic               pd;
    logic               test;
    logic               mult;
    logic [TUNE_W-1:0]  tune;
  } cfg_word_t;
endpackage

// File: rtl/cfg_edge_sync.sv
module cfg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cfg_in_reg.sv
module cfg_in_reg
  import cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_evt_i,
  input  logic              upd_evt_i,
  input  logic [BYTE_W-1:0] data_i,
  output cfg_word_t         word_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              serial_o
);
  logic [PTR_W-1:0]  ptr_q;
  logic              serial_q;
  logic [WORD_W-1:0] word_w;
  logic [WORD_W-1:0] shift_w;
  logic [BYTE_W-1:0] lane_q [NUM_BYTES];

  assign shift_w = {data_i[BYTE_W-1], word_w[WORD_W-1:1]};

  // byte lanes: lane 0 is the most significant byte; no reset by intent
  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_lane
    localparam int HI = WORD_W - 1 - k * BYTE_W;
    logic              lane_we;
    logic [BYTE_W-1:0] lane_nx;
    assign lane_we = serial_q ? wr_evt_i : (wr_evt_i && ptr_q == PTR_W'(k));
    assign lane_nx = serial_q ? shift_w[HI -: BYTE_W] : data_i;
    always_ff @(posedge clk_i) begin
      if (lane_we) lane_q[k] <= lane_nx;
    end
    assign word_w[HI -: BYTE_W] = lane_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (upd_evt_i) begin
      ptr_q <= '0;
    end else if (wr_evt_i && !serial_q && ptr_q < PTR_W'(NUM_BYTES)) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      serial_q <= 1'b0;
    end else if (!serial_q && wr_evt_i && ptr_q == '0 && data_i[2:0] == MODE_KEY) begin
      serial_q <= 1'b1;
    end
  end

  assign word_o   = cfg_word_t'(word_w);
  assign ptr_o    = ptr_q;
  assign serial_o = serial_q;
endmodule

// File: rtl/cfg_active_reg.sv
module cfg_active_reg
  import cfg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      upd_evt_i,
  input  cfg_word_t word_i,
  output cfg_word_t act_o,
  output logic      err_o
);
  cfg_word_t act_q;
  logic      err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      err_q <= 1'b0;
    end else if (upd_evt_i) begin
      if (word_i.test) begin
        err_q <= 1'b1;
      end else begin
        act_q <= word_i;
        err_q <= 1'b0;
      end
    end
  end

  assign act_o = act_q;
  assign err_o = err_q;
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_clk_i,
  input  logic               upd_i,
  input  logic [BYTE_W-1:0]  data_i,
  output logic [TUNE_W-1:0]  tune_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic               mult_en_o,
  output logic               pwr_dn_o,
  output logic               serial_mode_o,
  output logic               test_err_o
);
  logic             wr_evt;
  logic             upd_evt;
  logic [PTR_W-1:0] ptr;
  cfg_word_t        in_word;
  cfg_word_t        act_word;

  cfg_edge_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(wr_clk_i), .rise_o(wr_evt)
  );

  cfg_edge_sync #(.STAGES(SYNC_STAGES)) u_upd_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(upd_i), .rise_o(upd_evt)
  );

  cfg_in_reg u_in_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_evt_i(wr_evt), .upd_evt_i(upd_evt),
    .data_i(data_i), .word_o(in_word), .ptr_o(ptr), .serial_o(serial_mode_o)
  );

  cfg_active_reg u_act_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_evt_i(upd_evt), .word_i(in_word),
    .act_o(act_word), .err_o(test_err_o)
  );

  assign tune_o    = act_word.tune;
  assign phase_o   = act_word.phase;
  assign mult_en_o = act_word.mult;
  assign pwr_dn_o  = act_word.pd;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk
  import cfg_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_evt_i,
  input logic               upd_evt_i,
  input logic [PTR_W-1:0]   ptr_i,
  input cfg_word_t          word_i,
  input logic               serial_i,
  input logic [TUNE_W-1:0]  tune_i,
  input logic [PHASE_W-1:0] phase_i,
  input logic               mult_i,
  input logic               pd_i,
  input logic               err_i
);
  // R2
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_evt_i && !upd_evt_i && !serial_i && ptr_i < PTR_W'(NUM_BYTES))
      |=> ptr_i == $past(ptr_i) + 1'b1);

  // R3
  ptr_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_i == PTR_W'(NUM_BYTES) && !upd_evt_i) |=> ptr_i == PTR_W'(NUM_BYTES));

  // R4
  ptr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_evt_i |=> ptr_i == '0);

  // R5
  serial_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serial_i |=> serial_i);

  // R9
  test_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_evt_i && word_i.test)
      |=> err_i && $stable(tune_i) && $stable(phase_i) && $stable(mult_i) && $stable(pd_i));

  // R2
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_evt_i && !word_i.test)
      |=> !err_i && tune_i == $past(word_i.tune) && phase_i == $past(word_i.phase)
          && pd_i == $past(word_i.pd) && mult_i == $past(word_i.mult));

  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_evt_i |=> $stable(tune_i) && $stable(phase_i) && $stable(mult_i) && $stable(pd_i));
endmodule

bind cfg_loader cfg_loader_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_evt_i(wr_evt), .upd_evt_i(upd_evt),
  .ptr_i(ptr), .word_i(in_word), .serial_i(serial_mode_o), .tune_i(tune_o),
  .phase_i(phase_o), .mult_i(mult_en_o), .pd_i(pwr_dn_o), .err_i(test_err_o)
);

// File: tb/tb_cfg_loader.sv
module tb_cfg_loader;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_clk_i = 1'b0;
  logic        upd_i = 1'b0;
  logic [7:0]  data_i = '0;
  logic [31:0] tune_o;
  logic [4:0]  phase_o;
  logic        mult_en_o, pwr_dn_o, serial_mode_o, test_err_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  cfg_loader dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_clk_i(wr_clk_i), .upd_i(upd_i),
    .data_i(data_i), .tune_o(tune_o), .phase_o(phase_o), .mult_en_o(mult_en_o),
    .pwr_dn_o(pwr_dn_o), .serial_mode_o(serial_mode_o), .test_err_o(test_err_o)
  );

  function automatic logic [39:0] got();
    return {phase_o, pwr_dn_o, 1'b0, mult_en_o, tune_o};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic wr_pulse(input logic [7:0] b);
    @(negedge clk_i); data_i = b; wr_clk_i = 1'b1;
    repeat (4) @(negedge clk_i);
    wr_clk_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic upd_pulse();
    @(negedge clk_i); upd_i = 1'b1;
    repeat (4) @(negedge clk_i);
    upd_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic load_bytes(input logic [39:0] w);
    for (int k = 4; k >= 0; k--) wr_pulse(w[k*8 +: 8]);
  endtask

  task automatic load_bits(input logic [39:0] w);
    for (int i = 0; i < 40; i++) wr_pulse({w[i], 7'h00});
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R1 outputs in reset", {23'd0, got()}, 64'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 flags after reset", {62'd0, serial_mode_o, test_err_o}, 64'd0);
    check("R1 outputs after reset", {23'd0, got()}, 64'd0);
  endtask

  task automatic t_parallel();
    logic [39:0] w = {8'h09, 32'h0E38E38E};
    load_bytes(w);
    upd_pulse();
    check("R2 byte order transfer", {24'd0, got()}, {24'd0, w});
  endtask

  task automatic t_latency();
    logic [39:0] old_w = got();
    logic [39:0] w = {8'hA0, 32'h12345678};
    load_bytes(w);
    @(negedge clk_i); upd_i = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R11 unchanged after two edges", {24'd0, got()}, {24'd0, old_w});
    @(negedge clk_i);
    check("R11 updated on third edge", {24'd0, got()}, {24'd0, w});
    upd_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_overrun();
    logic [39:0] w = {8'h11, 32'h89ABCDEF};
    load_bytes(w);
    wr_pulse(8'hFF);
    wr_pulse(8'h55);
    upd_pulse();
    check("R3 extra bytes ignored", {24'd0, got()}, {24'd0, w});
  endtask

  task automatic t_partial();
    wr_pulse(8'hF8);
    upd_pulse();
    check("R4 only B0 rewritten", {24'd0, got()}, {24'd0, 8'hF8, 32'h89ABCDEF});
    wr_pulse(8'h00);
    wr_pulse(8'h42);
    upd_pulse();
    check("R4 pointer restarts at B0", {24'd0, got()}, {24'd0, 8'h00, 32'h42ABCDEF});
  endtask

  task automatic t_test_err();
    logic [39:0] prev = got();
    wr_pulse(8'h02);
    upd_pulse();
    check("R9 refused word keeps outputs", {24'd0, got()}, {24'd0, prev});
    check("R9 error flag set", {63'd0, test_err_o}, 64'd1);
    wr_pulse(8'h00);
    upd_pulse();
    check("R9 error cleared by accepted word", {63'd0, test_err_o}, 64'd0);
  endtask

  task automatic t_pwrdn();
    logic [39:0] w = {8'h50, 32'hCAFEF00D};
    wr_pulse(8'h04);
    upd_pulse();
    check("R10 power-down active", {63'd0, pwr_dn_o}, 64'd1);
    load_bytes(w);
    upd_pulse();
    check("R10 write accepted while powered down", {24'd0, got()}, {24'd0, w});
  endtask

  task automatic t_reset_keep();
    logic [39:0] w = {8'h30, 32'h0BADBEEF};
    load_bytes(w);
    do_reset();
    check("R1 outputs cleared by reset", {24'd0, got()}, 64'd0);
    upd_pulse();
    check("R8 staged word survives reset", {24'd0, got()}, {24'd0, w});
  endtask

  task automatic t_serial();
    logic [39:0] w = {8'hD1, 32'hA5C30F96};
    wr_pulse(8'h03);
    check("R5 bit mode entered", {63'd0, serial_mode_o}, 64'd1);
    load_bits(w);
    upd_pulse();
    check("R6 serial word transfer", {24'd0, got()}, {24'd0, w});
    check("R5 bit mode persists", {63'd0, serial_mode_o}, 64'd1);
  endtask

  task automatic t_serial_extra();
    logic [39:0] a = {8'h88, 32'h13579BDF};
    logic [39:0] e = {1'b1, a[39:1]};
    e[33] = 1'b0;
    load_bits(a);
    wr_pulse(8'h80);
    upd_pulse();
    check("R7 extra bit shifts word", {24'd0, got()}, {24'd0, e});
    do_reset();
    check("R5 reset selects byte mode", {63'd0, serial_mode_o}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all R): actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_parallel();
    t_latency();
    t_overrun();
    t_partial();
    t_test_err();
    t_pwrdn();
    t_reset_keep();
    t_serial();
    t_serial_extra();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule